// File: doc/BRIEF.md
# Double-Buffered Quad DAC Register Front End

This block is the digital register front end of a four-channel, 10-bit converter driven from a parallel bus. A host writes one code per cycle into one of four input registers, using active-low chip select and write strobes, a 2-bit channel address and a 10-bit data word. The write takes effect when the write strobe rises. Each channel has a second register stage, the DAC register, which drives the channel's code output. An active-low load strobe moves all four input registers into the DAC registers at once, so all outputs change together.

Every strobe passes through a two-flop synchronizer into the system clock domain. An active-low clear empties both register stages at once, without waiting for a clock. Its release is synchronized, and any write still in flight is discarded. An active-low power-down input and a gain-select input reach the outputs through their own synchronizers as status bits.

Top module: `quad_dac_regbank`

## Requirements
- R1: After power-on reset every DAC code output is zero, `pwrdn_o` is 0 and `gain_o` is 0 (one-times range).
- R2: A write completes when `wr_n` rises while `cs_n` is low. It loads the addressed input register. No DAC output changes while `load_n` stays high.
- R3: A write strobe given while `cs_n` is high has no effect on any input register. This is observed through the DAC outputs after a later load.
- R4: Address value k (bit 1 is the MSB) selects channel k. The code of channel k appears on `dac_code_o[k*10 +: 10]`, and data bit 9 is the code MSB.
- R5: Driving `load_n` low copies all four input registers into the DAC registers. All four DAC outputs take their new values in the same clock cycle.
- R6: Load is level sensitive. While `load_n` stays low, a completed write reaches the DAC output within a few clocks, without a further load edge.
- R7: Driving `clr_n` low sets every DAC output to zero at once, without a clock edge. It also zeroes every input register.
- R8: While `clr_n` is low, a write or a held load leaves all registers at zero. A write strobe that completes during clear is discarded.
- R9: `pwrdn_o` equals the inverse of `pd_n` after two clock edges. One flag covers all channels.
- R10: `gain_o` follows `gain_sel` after two clock edges. The value 0 selects the one-times range and 1 selects the two-times range.
- R11: A write changes only the addressed input register. After a load, the other channels keep their previous codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; a write completes on its rising edge |
| addr | input | 2 | Channel address |
| data | input | 10 | Code to write; bit 9 is the MSB |
| load_n | input | 1 | Active-low level-sensitive transfer to the DAC registers |
| clr_n | input | 1 | Active-low asynchronous clear of both register stages |
| pd_n | input | 1 | Active-low power-down request |
| gain_sel | input | 1 | Output range select: 0 one times, 1 two times |
| dac_code_o | output | 40 | Four DAC codes, channel k in bits k*10 +: 10 |
| pwrdn_o | output | 1 | Power-down flag shared by all channels |
| gain_o | output | 1 | Synchronized range select |

## Verification
The clear can coincide with a write completing, and with a load that is being held low. The bench holds `load_n` low, drops `clr_n`, and runs a complete write strobe on a nonzero code inside the clear window. After the clear is released, every DAC output must still read zero. Because the load is still held, the DAC outputs track the input registers, so a zero reading also shows that the discarded write never reached its input register.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   parameter int QD_NUM_CH   = 4;
   parameter int QD_CODE_W   = 10;
   parameter int QD_SYNC_STG = 2;

   typedef enum logic {
      GAIN_X1 = 1'b0,
      GAIN_X2 = 1'b1
   } gain_sel_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= RST_VAL;
      else        stg_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= RST_VAL;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/qdac_wr_decode.sv
module qdac_wr_decode #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 10,
   localparam int ADDR_W = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              wr_s,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] data,
   output logic [NUM_CH-1:0] wr_en,
   output logic [CODE_W-1:0] wr_data
);

   logic              wr_prev_q;
   logic              shd_vld_q;
   logic [ADDR_W-1:0] shd_addr_q;
   logic [CODE_W-1:0] shd_data_q;
   logic              commit;

   // Capture bus contents while the strobe is low; commit on its rise.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev_q  <= 1'b1;
         shd_vld_q  <= 1'b0;
         shd_addr_q <= '0;
         shd_data_q <= '0;
      end else begin
         wr_prev_q <= wr_s;
         if (!wr_s) begin
            shd_vld_q <= !cs_s;
            if (!cs_s) begin
               shd_addr_q <= addr;
               shd_data_q <= data;
            end
         end else begin
            shd_vld_q <= 1'b0;
         end
      end
   end

   assign commit  = wr_s && !wr_prev_q && shd_vld_q;
   assign wr_data = shd_data_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign wr_en[c] = commit && (shd_addr_q == ADDR_W'(c));
   end

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              load,
   output logic [CODE_W-1:0] inp_q,
   output logic [CODE_W-1:0] dac_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     inp_q <= '0;
      else if (wr_en) inp_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dac_q <= '0;
      else if (load) dac_q <= inp_q;
   end

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
   import qdac_pkg::*;
#(
   parameter int NUM_CH   = QD_NUM_CH,
   parameter int CODE_W   = QD_CODE_W,
   parameter int SYNC_STG = QD_SYNC_STG,
   localparam int ADDR_W  = $clog2(NUM_CH),
   localparam int OUT_W   = NUM_CH * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CODE_W-1:0] data,
   input  logic              load_n,
   input  logic              clr_n,
   input  logic              pd_n,
   input  logic              gain_sel,
   output logic [OUT_W-1:0]  dac_code_o,
   output logic              pwrdn_o,
   output logic              gain_o
);

   // Elaboration-time parameter checks
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("quad_dac_regbank: NUM_CH must be a power of two, at least 2");
   end
   if (CODE_W < 1) begin : g_bad_w
      $error("quad_dac_regbank: CODE_W must be positive");
   end
   if (SYNC_STG < 2) begin : g_bad_sync
      $error("quad_dac_regbank: SYNC_STG must be at least 2");
   end

   // Clear: asserts at once, releases through a synchronizer
   logic clr_any_n;
   logic reg_rst_n;

   assign clr_any_n = rst_n & clr_n;

   qdac_sync #(.W(1), .STAGES(SYNC_STG), .RST_VAL(1'b0)) i_rst_sync (
      .clk   (clk),
      .rst_n (clr_any_n),
      .d     (1'b1),
      .q     (reg_rst_n)
   );

   // Strobe synchronizers, flushed by clear
   logic [2:0] strb_raw;
   logic [2:0] strb_s;
   logic       cs_s;
   logic       wr_s;
   logic       load_act;

   assign strb_raw = {load_n, wr_n, cs_n};

   qdac_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b111)) i_strb_sync (
      .clk   (clk),
      .rst_n (reg_rst_n),
      .d     (strb_raw),
      .q     (strb_s)
   );

   assign cs_s     = strb_s[0];
   assign wr_s     = strb_s[1];
   assign load_act = !strb_s[2];

   // Status synchronizers, reset only at power-on
   logic [1:0] stat_s;
   gain_sel_e  gain_q;

   qdac_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL({GAIN_X1, 1'b1})) i_stat_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({gain_sel, pd_n}),
      .q     (stat_s)
   );

   assign gain_q  = gain_sel_e'(stat_s[1]);
   assign gain_o  = gain_q;
   assign pwrdn_o = !stat_s[0];

   // Write address decode
   logic [NUM_CH-1:0] wr_en;
   logic [CODE_W-1:0] wr_data;

   qdac_wr_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_wr_decode (
      .clk     (clk),
      .rst_n   (reg_rst_n),
      .cs_s    (cs_s),
      .wr_s    (wr_s),
      .addr    (addr),
      .data    (data),
      .wr_en   (wr_en),
      .wr_data (wr_data)
   );

   // Per-channel register pairs
   logic [OUT_W-1:0] inp_flat;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      qdac_channel #(.CODE_W(CODE_W)) i_channel (
         .clk     (clk),
         .rst_n   (clr_any_n & reg_rst_n),
         .wr_en   (wr_en[c]),
         .wr_data (wr_data),
         .load    (load_act),
         .inp_q   (inp_flat[c*CODE_W +: CODE_W]),
         .dac_q   (dac_code_o[c*CODE_W +: CODE_W])
      );
   end

endmodule

// File: rtl/qdac_regbank_chk.sv
module qdac_regbank_chk #(
   parameter int NUM_CH = 4,
   parameter int CODE_W = 10,
   localparam int OUT_W = NUM_CH * CODE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic              pd_n,
   input logic              gain_sel,
   input logic              load_act,
   input logic              reg_rst_n,
   input logic [NUM_CH-1:0] wr_en,
   input logic [OUT_W-1:0]  inp_flat,
   input logic [OUT_W-1:0]  dac_code_o,
   input logic              pwrdn_o,
   input logic              gain_o
);

   logic [1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cyc_q <= '0;
      else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> dac_code_o == '0);                                   // R7

   AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !load_act |=> $stable(dac_code_o));                             // R2

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (load_act && reg_rst_n) |=> dac_code_o == $past(inp_flat));     // R5

   AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));                                               // R4

   AST_PD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd3) |-> pwrdn_o == !$past(pd_n, 2));                // R9

   AST_GAIN_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == 2'd3) |-> gain_o == $past(gain_sel, 2));              // R10

endmodule

bind quad_dac_regbank qdac_regbank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr_n      (clr_n),
   .pd_n       (pd_n),
   .gain_sel   (gain_sel),
   .load_act   (load_act),
   .reg_rst_n  (reg_rst_n),
   .wr_en      (wr_en),
   .inp_flat   (inp_flat),
   .dac_code_o (dac_code_o),
   .pwrdn_o    (pwrdn_o),
   .gain_o     (gain_o)
);

// File: tb/test_quad_dac_regbank.sv
module test_quad_dac_regbank;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n, cs_n, wr_n, load_n, clr_n, pd_n, gain_sel;
   logic [1:0]  addr;
   logic [9:0]  data;
   logic [39:0] dac_code_o;
   logic        pwrdn_o, gain_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_dac_regbank i_quad_dac_regbank (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
      .data(data), .load_n(load_n), .clr_n(clr_n), .pd_n(pd_n),
      .gain_sel(gain_sel), .dac_code_o(dac_code_o), .pwrdn_o(pwrdn_o),
      .gain_o(gain_o)
   );

   task automatic check(string req, logic [39:0] act, logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [39:0] pack4(logic [9:0] c0, c1, c2, c3);
      return {c3, c2, c1, c0};
   endfunction

   task automatic bus_write(logic [1:0] a, logic [9:0] d, bit sel);
      addr = a; data = d; cs_n = !sel;
      cycles(1); wr_n = 1'b0;
      cycles(4); wr_n = 1'b1;
      cycles(4); cs_n = 1'b1;
      cycles(2);
   endtask

   // Pulse load; every sample must show all channels old or all new.
   task automatic load_pulse(string req, logic [39:0] old_v, logic [39:0] new_v);
      load_n = 1'b0;
      for (int i = 0; i < 6; i++) begin
         cycles(1);
         checks++;
         if (dac_code_o !== old_v && dac_code_o !== new_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h or %h", req, dac_code_o, old_v, new_v);
         end
      end
      load_n = 1'b1;
      cycles(3);
      check(req, dac_code_o, new_v);
   endtask

   task automatic t_reset;                    // R1
      check("R1 codes", dac_code_o, '0);
      check("R1 pwrdn", {39'd0, pwrdn_o}, 40'd0);
      check("R1 gain",  {39'd0, gain_o},  40'd0);
   endtask

   task automatic t_write_no_load;            // R2
      bus_write(2'd0, 10'h200, 1'b1);
      bus_write(2'd1, 10'h0AA, 1'b1);
      bus_write(2'd2, 10'h155, 1'b1);
      bus_write(2'd3, 10'h3FF, 1'b1);
      cycles(4);
      check("R2 no dac change without load", dac_code_o, '0);
   endtask

   task automatic t_load_map;                 // R4 R5
      load_pulse("R5 simultaneous load", '0, pack4(10'h200, 10'h0AA, 10'h155, 10'h3FF));
      check("R4 ch0 msb", {30'd0, dac_code_o[9:0]},   40'h200);
      check("R4 ch3",     {30'd0, dac_code_o[39:30]}, 40'h3FF);
   endtask

   task automatic t_cs_ignored;               // R3 R11
      logic [39:0] prev = pack4(10'h200, 10'h0AA, 10'h155, 10'h3FF);
      bus_write(2'd2, 10'h0F0, 1'b0);
      load_pulse("R3 cs high ignored", prev, prev);
      bus_write(2'd1, 10'h011, 1'b1);
      load_pulse("R11 only addressed channel", prev,
                 pack4(10'h200, 10'h011, 10'h155, 10'h3FF));
   endtask

   task automatic t_transparent;              // R6
      load_n = 1'b0;
      cycles(4);
      bus_write(2'd3, 10'h123, 1'b1);
      cycles(2);
      check("R6 transparent load", dac_code_o, pack4(10'h200, 10'h011, 10'h155, 10'h123));
      load_n = 1'b1;
      cycles(3);
   endtask

   task automatic t_clear_async;              // R7
      clr_n = 1'b0;
      #1;
      check("R7 async clear", dac_code_o, '0);
      cycles(3);
      clr_n = 1'b1;
      cycles(4);
      load_pulse("R7 input regs cleared", '0, '0);
   endtask

   task automatic t_clear_wins;               // R8
      bus_write(2'd0, 10'h2C3, 1'b1);
      load_pulse("R8 setup", '0, pack4(10'h2C3, 10'h0, 10'h0, 10'h0));
      load_n = 1'b0;
      cycles(3);
      clr_n = 1'b0;
      cycles(1);
      bus_write(2'd2, 10'h1E7, 1'b1);
      check("R8 zero during clear", dac_code_o, '0);
      clr_n = 1'b1;
      cycles(6);
      check("R8 write discarded after clear", dac_code_o, '0);
      load_n = 1'b1;
      cycles(3);
   endtask

   task automatic t_pd;                       // R9
      pd_n = 1'b0;
      cycles(1);
      check("R9 pd latency 1", {39'd0, pwrdn_o}, 40'd0);
      cycles(1);
      check("R9 pd asserted", {39'd0, pwrdn_o}, 40'd1);
      pd_n = 1'b1;
      cycles(2);
      check("R9 pd released", {39'd0, pwrdn_o}, 40'd0);
   endtask

   task automatic t_gain;                     // R10
      gain_sel = 1'b1;
      cycles(1);
      check("R10 gain latency 1", {39'd0, gain_o}, 40'd0);
      cycles(1);
      check("R10 gain x2", {39'd0, gain_o}, 40'd1);
      gain_sel = 1'b0;
      cycles(2);
      check("R10 gain x1", {39'd0, gain_o}, 40'd0);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; load_n = 1'b1; clr_n = 1'b1;
      pd_n = 1'b1; gain_sel = 1'b0; addr = '0; data = '0;
      cycles(3);
      rst_n = 1'b1;
      cycles(3);
      t_reset();
      t_write_no_load();
      t_load_map();
      t_cs_ignored();
      t_transparent();
      t_clear_async();
      t_clear_wins();
      t_pd();
      t_gain();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule